// File: doc/BRIEF.md
# Prioritized Interrupt Entry Sequencer

This block runs the entry half of interrupt handling for an 8-bit processor core with a 16-bit address space. Four request lines (reset, non-maskable, fast and normal) each set a pending flag held inside the block. When the core signals an instruction boundary and the sequencer is idle, the block picks the highest-priority pending line that its mask bit allows. It then runs that line's entry sequence on a byte-wide memory bus and hands the new program counter, stack pointer, condition-code byte and direct-page value back to the core.

A full entry pushes the whole programmer model onto the system stack. A fast entry pushes only the program counter and the condition-code byte. A reset entry pushes nothing and initialises the machine state instead. In every case the block reads a two-byte vector, high byte first, and loads it into the program counter. It then drops the serviced pending flag and pulses `done_o` for one cycle.

The condition-code byte uses these bit positions: bit 7 marks that the entire state was stacked, bit 6 masks the fast request, and bit 4 masks the normal request. Read data on the bus is taken in the same cycle as the address.

Top module: `irq_entry_seq`

## Requirements
- R1: Priority runs reset (req bit 3) over non-maskable (bit 2) over fast (bit 1) over normal (bit 0). Selection happens only in the clock cycle in which `boundary_i` is high and the block is idle. A boundary pulse that arrives while a sequence is running is ignored.
- R2: A reset entry performs no write. It ORs 0x50 into the condition codes, returns 0 as the direct-page value, leaves S unchanged, and loads PC from the bytes at 0xFFFE (high) and 0xFFFF (low).
- R3: A non-maskable entry sets bit 7 of the condition codes before stacking. It pushes 12 bytes in this order: PC low, PC high, U low, U high, Y low, Y high, X low, X high, DP, B, A, CC. The final condition codes are the stacked value OR 0x50, and the vector is read at 0xFFFC.
- R4: A fast entry is taken only when CC bit 6 is 0. It clears bit 7 and pushes PC low, PC high, then CC. The final condition codes are the stacked value OR 0x50, and the vector is read at 0xFFF6.
- R5: A normal entry is taken only when CC bit 4 is 0. It sets bit 7 and pushes the same 12 bytes as R3. The final condition codes are the stacked value OR 0x10, and the vector is read at 0xFFF8.
- R6: A masked request stays pending, and a lower-priority request that is unmasked is serviced in its place.
- R7: Every push first decrements S and then writes at the new S. The returned S equals the entry S minus the number of bytes pushed.
- R8: When the entry ends, the serviced pending flag is cleared and every other pending flag is kept.
- R9: A boundary with no eligible request causes no bus access and no `done_o` pulse. The bus never reads and writes in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| boundary_i | input | 1 | Instruction boundary strobe from the core |
| req_i | input | 4 | Request pulses: bit 3 reset, 2 non-maskable, 1 fast, 0 normal |
| cc_i | input | 8 | Current condition-code byte |
| dp_i | input | 8 | Direct-page register |
| a_i | input | 8 | Accumulator A |
| b_i | input | 8 | Accumulator B |
| x_i | input | 16 | Index register X |
| y_i | input | 16 | Index register Y |
| u_i | input | 16 | User stack pointer |
| s_i | input | 16 | System stack pointer |
| pc_i | input | 16 | Return program counter |
| mem_addr_o | output | 16 | Bus address |
| mem_we_o | output | 1 | Bus write strobe |
| mem_re_o | output | 1 | Bus read strobe |
| mem_wdata_o | output | 8 | Bus write data |
| mem_rdata_i | input | 8 | Bus read data, valid in the same cycle |
| busy_o | output | 1 | Entry sequence in progress |
| done_o | output | 1 | One-cycle pulse when the new state is valid |
| pend_o | output | 4 | Pending flags, same bit order as req_i |
| pc_o | output | 16 | New program counter |
| s_o | output | 16 | New system stack pointer |
| cc_o | output | 8 | New condition-code byte |
| dp_o | output | 8 | New direct-page value |

## Verification
The assertions check four things on every cycle. Consecutive stack writes step down by one address. Read and write never overlap. A reset entry never writes. A fast or normal entry is never running while its mask bit, as captured at entry, is set. They also check that the grant is one-hot and that a cleared pending flag stays clear. Only the bench scenarios can show the full picture: the exact byte order on the stack, the vector addresses, the final condition-code and stack-pointer values, and the choice made across every combination of pending lines and mask settings. Those scenarios also show that a boundary pulse during an entry leaves a second request waiting.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;

  // Source index equals its bit in req_i / pend_o; higher index wins.
  typedef enum logic [1:0] {
    SRC_IRQ  = 2'd0,
    SRC_FIRQ = 2'd1,
    SRC_NMI  = 2'd2,
    SRC_RST  = 2'd3
  } src_e;

  typedef enum logic [3:0] {
    SL_PCL, SL_PCH, SL_UL, SL_UH, SL_YL, SL_YH,
    SL_XL, SL_XH, SL_DP, SL_B, SL_A, SL_CC
  } slot_e;

  localparam int CC_E = 7;
  localparam int CC_F = 6;
  localparam int CC_I = 4;
  localparam int FULL_PUSH = 12;
  localparam int FAST_PUSH = 3;

  function automatic int unsigned push_count(input src_e k);
    case (k)
      SRC_RST:  return 0;
      SRC_FIRQ: return FAST_PUSH;
      default:  return FULL_PUSH;
    endcase
  endfunction

  // Condition codes as stacked: entire flag adjusted, masks untouched.
  function automatic logic [7:0] stacked_cc(input src_e k, input logic [7:0] cc);
    logic [7:0] r;
    r = cc;
    if (k == SRC_NMI || k == SRC_IRQ) r[CC_E] = 1'b1;
    if (k == SRC_FIRQ) r[CC_E] = 1'b0;
    return r;
  endfunction

  // Mask bits ORed in once stacking is over.
  function automatic logic [7:0] mask_set(input src_e k);
    logic [7:0] m;
    m = '0;
    m[CC_I] = 1'b1;
    if (k != SRC_IRQ) m[CC_F] = 1'b1;
    return m;
  endfunction

  function automatic slot_e slot_of(input logic fast, input logic [3:0] idx);
    if (fast) return (idx == 4'd0) ? SL_PCL : (idx == 4'd1) ? SL_PCH : SL_CC;
    return slot_e'(idx);
  endfunction

endpackage

// File: rtl/irq_pend_arb.sv
module irq_pend_arb #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req_i,
  input  logic [N-1:0] clr_i,
  input  logic [N-1:0] ok_i,
  output logic [N-1:0] pend_o,
  output logic [N-1:0] grant_o,
  output logic         any_o
);
  logic [N-1:0] pend_q;
  logic [N-1:0] elig;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= (pend_q & ~clr_i) | req_i;
  end

  assign elig = pend_q & ok_i;

  always_comb begin
    grant_o = '0;
    for (int i = 0; i < N; i++) begin
      if (elig[i]) begin
        grant_o = '0;
        grant_o[i] = 1'b1;
      end
    end
  end

  assign any_o  = |elig;
  assign pend_o = pend_q;

  assert_onehot_grant_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_o));
  assert_low_yields_R1: assert property (@(posedge clk) disable iff (!rst_n)
    grant_o[0] |-> (pend_o[N-1:2] == '0));
  assert_clear_sticks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend_o & $past(clr_i) & ~$past(req_i)) == '0));
endmodule

// File: rtl/irq_stack_mux.sv
module irq_stack_mux
  import irq_seq_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8,
  parameter int IW = 4
) (
  input  logic          fast_i,
  input  logic [IW-1:0] idx_i,
  input  logic [AW-1:0] pc_i,
  input  logic [AW-1:0] u_i,
  input  logic [AW-1:0] y_i,
  input  logic [AW-1:0] x_i,
  input  logic [DW-1:0] dp_i,
  input  logic [DW-1:0] b_i,
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] cc_i,
  output logic [DW-1:0] byte_o
);
  slot_e slot;
  assign slot = slot_of(fast_i, 4'(idx_i));

  always_comb begin
    case (slot)
      SL_PCL:  byte_o = pc_i[DW-1:0];
      SL_PCH:  byte_o = pc_i[AW-1:DW];
      SL_UL:   byte_o = u_i[DW-1:0];
      SL_UH:   byte_o = u_i[AW-1:DW];
      SL_YL:   byte_o = y_i[DW-1:0];
      SL_YH:   byte_o = y_i[AW-1:DW];
      SL_XL:   byte_o = x_i[DW-1:0];
      SL_XH:   byte_o = x_i[AW-1:DW];
      SL_DP:   byte_o = dp_i;
      SL_B:    byte_o = b_i;
      SL_A:    byte_o = a_i;
      default: byte_o = cc_i;
    endcase
  end
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
  import irq_seq_pkg::*;
#(
  parameter int          AW      = 16,
  parameter int          DW      = 8,
  parameter logic [15:0] VEC_RST = 16'hFFFE,
  parameter logic [15:0] VEC_NMI = 16'hFFFC,
  parameter logic [15:0] VEC_IRQ = 16'hFFF8,
  parameter logic [15:0] VEC_FIR = 16'hFFF6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          boundary_i,
  input  logic [3:0]    req_i,
  input  logic [DW-1:0] cc_i,
  input  logic [DW-1:0] dp_i,
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic [AW-1:0] x_i,
  input  logic [AW-1:0] y_i,
  input  logic [AW-1:0] u_i,
  input  logic [AW-1:0] s_i,
  input  logic [AW-1:0] pc_i,
  output logic [AW-1:0] mem_addr_o,
  output logic          mem_we_o,
  output logic          mem_re_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic [DW-1:0] mem_rdata_i,
  output logic          busy_o,
  output logic          done_o,
  output logic [3:0]    pend_o,
  output logic [AW-1:0] pc_o,
  output logic [AW-1:0] s_o,
  output logic [DW-1:0] cc_o,
  output logic [DW-1:0] dp_o
);
  localparam int NSRC = 4;
  localparam int IW   = $clog2(FULL_PUSH + 1);

  typedef enum logic [1:0] {ST_IDLE, ST_PUSH, ST_VHI, ST_VLO} st_e;

  st_e             state;
  src_e            kind;
  logic [IW-1:0]   idx;
  logic [AW-1:0]   s_w, pc_w, x_w, y_w, u_w;
  logic [DW-1:0]   cc_w, dp_w, a_w, b_w, vec_hi;
  logic [NSRC-1:0] ok, grant, clr;
  logic            any_elig, start_evt, push_last;
  logic [DW-1:0]   push_byte;
  logic [AW-1:0]   vec_base;
  src_e            win;

  // Eligibility: reset and non-maskable always; others by their mask bit.
  assign ok = {1'b1, 1'b1, ~cc_i[CC_F], ~cc_i[CC_I]};

  irq_pend_arb #(.N(NSRC)) u_arb (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .clr_i(clr), .ok_i(ok),
    .pend_o(pend_o), .grant_o(grant), .any_o(any_elig)
  );

  always_comb begin
    win = SRC_IRQ;
    for (int i = 0; i < NSRC; i++) if (grant[i]) win = src_e'(i);
  end

  assign start_evt = (state == ST_IDLE) && boundary_i && any_elig;
  assign push_last = (32'(idx) == push_count(kind) - 1);
  assign clr       = (state == ST_VLO) ? (NSRC'(1) << kind) : '0;

  always_comb begin
    case (kind)
      SRC_RST:  vec_base = VEC_RST;
      SRC_NMI:  vec_base = VEC_NMI;
      SRC_FIRQ: vec_base = VEC_FIR;
      default:  vec_base = VEC_IRQ;
    endcase
  end

  irq_stack_mux #(.AW(AW), .DW(DW), .IW(IW)) u_mux (
    .fast_i(kind == SRC_FIRQ), .idx_i(idx), .pc_i(pc_w), .u_i(u_w),
    .y_i(y_w), .x_i(x_w), .dp_i(dp_w), .b_i(b_w), .a_i(a_w), .cc_i(cc_w),
    .byte_o(push_byte)
  );

  always_comb begin
    mem_we_o    = (state == ST_PUSH);
    mem_re_o    = (state == ST_VHI) || (state == ST_VLO);
    mem_wdata_o = mem_we_o ? push_byte : '0;
    case (state)
      ST_PUSH: mem_addr_o = s_w - 1'b1;
      ST_VHI:  mem_addr_o = vec_base;
      ST_VLO:  mem_addr_o = vec_base + 1'b1;
      default: mem_addr_o = '0;
    endcase
  end

  assign busy_o = (state != ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE; kind <= SRC_IRQ; idx <= '0;
      s_w <= '0; pc_w <= '0; x_w <= '0; y_w <= '0; u_w <= '0;
      cc_w <= '0; dp_w <= '0; a_w <= '0; b_w <= '0; vec_hi <= '0;
      done_o <= 1'b0; pc_o <= '0; s_o <= '0; cc_o <= '0; dp_o <= '0;
    end else begin
      done_o <= 1'b0;
      case (state)
        ST_IDLE: if (start_evt) begin
          kind <= win; idx <= '0;
          s_w <= s_i; pc_w <= pc_i; x_w <= x_i; y_w <= y_i; u_w <= u_i;
          dp_w <= dp_i; a_w <= a_i; b_w <= b_i;
          cc_w <= stacked_cc(win, cc_i);
          state <= (win == SRC_RST) ? ST_VHI : ST_PUSH;
        end
        ST_PUSH: begin
          s_w <= s_w - 1'b1;
          idx <= idx + 1'b1;
          if (push_last) state <= ST_VHI;
        end
        ST_VHI: begin
          vec_hi <= mem_rdata_i;
          state  <= ST_VLO;
        end
        default: begin
          pc_o   <= {vec_hi, mem_rdata_i};
          s_o    <= s_w;
          cc_o   <= cc_w | mask_set(kind);
          dp_o   <= (kind == SRC_RST) ? '0 : dp_w;
          done_o <= 1'b1;
          state  <= ST_IDLE;
        end
      endcase
    end
  end

  assert_predec_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we_o && $past(mem_we_o)) |-> (mem_addr_o == $past(mem_addr_o) - 1'b1));
  assert_bus_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we_o && mem_re_o));
  assert_reset_no_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && kind == SRC_RST) |-> !mem_we_o);
  assert_fast_mask_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && kind == SRC_FIRQ) |-> !cc_w[CC_F]);
  assert_irq_mask_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && kind == SRC_IRQ) |-> !cc_w[CC_I]);
endmodule

// File: tb/irq_entry_seq_bench.sv
module irq_entry_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        boundary_i = 1'b0;
  logic [3:0]  req_i = '0;
  logic [7:0]  cc_i = '0, dp_i = '0, a_i = '0, b_i = '0;
  logic [15:0] x_i = '0, y_i = '0, u_i = '0, s_i = '0, pc_i = '0;
  logic [15:0] mem_addr_o, pc_o, s_o;
  logic        mem_we_o, mem_re_o, busy_o, done_o;
  logic [7:0]  mem_wdata_o, mem_rdata_i, cc_o, dp_o;
  logic [3:0]  pend_o;

  int tests = 0;
  int fails = 0;

  always #4 clk = ~clk;  // 125 MHz

  // Bus model: every byte is its low address byte xor 0x3C.
  assign mem_rdata_i = mem_addr_o[7:0] ^ 8'h3C;

  irq_entry_seq u_irq_entry_seq (
    .clk(clk), .rst_n(rst_n), .boundary_i(boundary_i), .req_i(req_i),
    .cc_i(cc_i), .dp_i(dp_i), .a_i(a_i), .b_i(b_i), .x_i(x_i), .y_i(y_i),
    .u_i(u_i), .s_i(s_i), .pc_i(pc_i), .mem_addr_o(mem_addr_o),
    .mem_we_o(mem_we_o), .mem_re_o(mem_re_o), .mem_wdata_o(mem_wdata_o),
    .mem_rdata_i(mem_rdata_i), .busy_o(busy_o), .done_o(done_o),
    .pend_o(pend_o), .pc_o(pc_o), .s_o(s_o), .cc_o(cc_o), .dp_o(dp_o)
  );

  logic [15:0] wlog_a [16];
  logic [7:0]  wlog_d [16];
  int wn, rn, dn;

  always @(posedge clk) begin
    if (!rst_n) begin
      wn <= 0; rn <= 0; dn <= 0;
    end else begin
      if (mem_we_o) begin
        if (wn < 16) begin wlog_a[wn] <= mem_addr_o; wlog_d[wn] <= mem_wdata_o; end
        wn <= wn + 1;
      end
      if (mem_re_o) rn <= rn + 1;
      if (done_o) dn <= dn + 1;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic restart();
    @(negedge clk); rst_n = 1'b0; boundary_i = 1'b0; req_i = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  function automatic logic [15:0] vec_word(input logic [15:0] va);
    logic [15:0] vb;
    vb = va + 16'd1;
    return {va[7:0] ^ 8'h3C, vb[7:0] ^ 8'h3C};
  endfunction

  task automatic run_case(input logic [3:0] pset, input logic [7:0] cc, input int sd);
    int winner;
    int n;
    logic [7:0]  full [12];
    logic [7:0]  scc, fcc;
    logic [15:0] va;
    bit seen;
    restart();
    cc_i = cc; dp_i = 8'h40 + 8'(sd); a_i = 8'hA0 ^ 8'(sd); b_i = 8'hB5 + 8'(sd);
    x_i = 16'h1357 + 16'(sd * 3); y_i = 16'h2468 ^ 16'(sd << 4);
    u_i = 16'h8ACE - 16'(sd); s_i = 16'h0300 + 16'(sd); pc_i = 16'hC000 + 16'(sd * 7);
    req_i = pset; @(negedge clk); req_i = '0;
    chk("R8 pend latched", 32'(pend_o), 32'(pset));
    boundary_i = 1'b1; @(negedge clk); boundary_i = 1'b0;
    seen = 0;
    for (int t = 0; t < 24 && !seen; t++) begin
      if (done_o) seen = 1; else @(negedge clk);
    end
    // Expected choice from priority and masks.
    if (pset[3]) winner = 3;
    else if (pset[2]) winner = 2;
    else if (pset[1] && !cc[6]) winner = 1;
    else if (pset[0] && !cc[4]) winner = 0;
    else winner = -1;
    if (winner < 0) begin
      chk("R9 no done", 32'(seen), 0);
      chk("R9 no writes", 32'(wn), 0);
      chk("R9 no reads", 32'(rn), 0);
      chk("R6 pending kept", 32'(pend_o), 32'(pset));
      return;
    end
    chk("R1 done seen", 32'(seen), 1);
    scc = cc;
    if (winner == 2 || winner == 0) scc[7] = 1'b1;
    if (winner == 1) scc[7] = 1'b0;
    fcc = scc | ((winner == 0) ? 8'h10 : 8'h50);
    full[0] = pc_i[7:0]; full[1] = pc_i[15:8]; full[2] = u_i[7:0]; full[3] = u_i[15:8];
    full[4] = y_i[7:0];  full[5] = y_i[15:8];  full[6] = x_i[7:0]; full[7] = x_i[15:8];
    full[8] = dp_i; full[9] = b_i; full[10] = a_i; full[11] = scc;
    n = (winner == 3) ? 0 : (winner == 1) ? 3 : 12;
    va = (winner == 3) ? 16'hFFFE : (winner == 2) ? 16'hFFFC :
         (winner == 1) ? 16'hFFF6 : 16'hFFF8;
    if (winner == 3) begin
      chk("R2 reset writes", 32'(wn), 0);
      chk("R2 reset dp", 32'(dp_o), 0);
    end else begin
      chk("R3 push count", 32'(wn), 32'(n));
      chk("R7 dp kept", 32'(dp_o), 32'(dp_i));
    end
    for (int k = 0; k < n && k < wn; k++) begin
      logic [7:0] eb;
      eb = (winner == 1 && k == 2) ? scc : full[k];
      chk((winner == 1) ? "R4 stack byte" : (winner == 0) ? "R5 stack byte" : "R3 stack byte",
          32'(wlog_d[k]), 32'(eb));
      chk("R7 stack addr", 32'(wlog_a[k]), 32'(s_i - 16'(k + 1)));
    end
    chk((winner == 3) ? "R2 vector" : (winner == 1) ? "R4 vector" :
        (winner == 0) ? "R5 vector" : "R3 vector", 32'(pc_o), 32'(vec_word(va)));
    chk("R7 final S", 32'(s_o), 32'(s_i - 16'(n)));
    chk((winner == 0) ? "R5 final cc" : (winner == 1) ? "R4 final cc" :
        (winner == 3) ? "R2 final cc" : "R3 final cc", 32'(cc_o), 32'(fcc));
    @(negedge clk);
    chk("R8 pending after entry", 32'(pend_o), 32'(pset & ~(4'b1 << winner)));
    chk("R1 single done", 32'(dn), 1);
  endtask

  initial begin
    restart();
    chk("R9 reset idle", 32'({busy_o, done_o, mem_we_o, mem_re_o, pend_o}), 0);
    for (int p = 0; p < 16; p++)
      for (int m = 0; m < 4; m++)
        run_case(4'(p), {1'b0, m[1], 1'b0, m[0], 4'b0101}, p * 4 + m);
    // R6: fast masked, normal unmasked -> normal served, fast kept.
    run_case(4'b0011, 8'h40, 70);
    // R1: boundary during an entry is ignored.
    restart();
    cc_i = 8'h00; s_i = 16'h0400;
    req_i = 4'b0101; @(negedge clk); req_i = '0;
    boundary_i = 1'b1; @(negedge clk); boundary_i = 1'b0;
    repeat (3) @(negedge clk);
    boundary_i = 1'b1; @(negedge clk); boundary_i = 1'b0;
    repeat (30) @(negedge clk);
    chk("R1 busy boundary ignored", 32'(dn), 1);
    chk("R1 lower still pending", 32'(pend_o), 32'(4'b0001));
    chk("R1 nmi vector", 32'(pc_o), 32'(vec_word(16'hFFFC)));
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule